// File: doc/BRIEF.md
# Serial Packet Deframer with Sync Hunt

This block sits behind a bit-level serial receiver and turns a raw bit stream into framed words. Bits enter one per cycle in which `bit_vld` is high, most significant bit first. While idle the block slides a window over the stream looking for a 16-bit synchronization word, which may start at any bit position. When the word matches, the next eight bits are taken as a header. The header carries a payload-size code, a channel type and a clear-to-send flag.

The size code picks the payload length: eight bits shifted left by the code. The payload is then packed into 8-bit words. Frames whose channel type equals the sample type carry alternating I and Q samples, and each word is tagged as I or Q. Any other channel type is a control frame, and its words carry start-of-frame and end-of-frame markers. A size code longer than the configured maximum flags an error and drops the frame. After the last payload bit, or after a rejected header, the block goes straight back to hunting, so frames may arrive back to back at unpredictable times.

Top module: `pkt_deframer`

## Requirements
- R1: After a synchronous active-low reset, and after a reset asserted in the middle of a frame, the block is hunting. `word_vld`, `frame_done` and `frame_err` are low, and `chan_type` and `cts` are zero.
- R2: A frame starts only after 16 consecutive valid bits equal `SYNC_WORD` (default 16'hF0A5), received MSB first. The match is found whatever the number of unrelated bits before it.
- R3: The eight valid bits after the sync word form the header, in arrival order: a 3-bit size code, then a 4-bit channel type, then the clear-to-send bit. The payload length in bits is 8 shifted left by the size code (8 up to 1024).
- R4: `chan_type`, `cts` and `frame_iq` are updated when a header is accepted, and they hold their values until the next accepted header.
- R5: When the channel type equals `IQ_TYPE` (default 4'h1), `frame_iq` is high. Each payload word is tagged with `word_q`: 0 (I) for the first word, then alternating. `word_sof` and `word_eof` stay low.
- R6: In a frame of any other channel type, `word_sof` is high on the first word only and `word_eof` is high on the last word only. `word_q` stays low.
- R7: Each group of 8 payload bits appears MSB first on `word_data`, with a one-cycle `word_vld` pulse in the cycle after its last bit is taken. A frame yields exactly length/8 words. `frame_done` pulses together with the last word.
- R8: If a header's size code selects a length above `MAX_BITS`, `frame_err` pulses for one cycle and no words are emitted. `chan_type` and `cts` keep their previous values, and the block hunts again starting with the next bit.
- R9: Payload bits are never taken as a sync word. Hunting restarts with the bit that follows the last payload bit, so a sync word placed right there is detected.
- R10: Cycles with `bit_vld` low are ignored, whatever the value on `bit_in`. The framing and the words are the same as for an unbroken stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_in | input | 1 | Serial data bit |
| bit_vld | input | 1 | Qualifies `bit_in` for this cycle |
| word_data | output | WORD_W | Assembled payload word |
| word_vld | output | 1 | One-cycle strobe for `word_data` |
| word_q | output | 1 | Sample tag in I/Q frames: 0 = I, 1 = Q |
| word_sof | output | 1 | First word of a control frame |
| word_eof | output | 1 | Last word of a control frame |
| frame_done | output | 1 | Pulse with the last word of a frame |
| frame_err | output | 1 | Pulse when a header asks for an over-long payload |
| frame_iq | output | 1 | Last accepted header was of the sample type |
| chan_type | output | 4 | Channel type of the last accepted header |
| cts | output | 1 | Clear-to-send bit of the last accepted header |

## Verification
The bench builds the block with `MAX_BITS` set to 256 and keeps the default sync word, word width and sample type. With that maximum, size codes 6 and 7 fall in the rejected range, so the error path can be reached with short stimulus. Code 5 becomes the exact boundary, and it is tested as a full 32-word I/Q frame. Control frames with a sync word inside their payload, back-to-back frames and gapped bit strobes complete the set.

// File: rtl/deframer_pkg.sv
// Shared types and helpers for the serial packet deframer.
// Assumes an 8-bit header laid out MSB-first as size code, channel type, clear-to-send.
package deframer_pkg;

    localparam int SIZE_W   = 3;
    localparam int CTYPE_W  = 4;
    localparam int HDR_W    = SIZE_W + CTYPE_W + 1;
    localparam int BASE_BITS = 8;
    localparam int LONGEST_BITS = BASE_BITS << ((1 << SIZE_W) - 1);

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_HDR,
        ST_BODY
    } df_state_t;

    typedef struct packed {
        logic [SIZE_W-1:0]  size;
        logic [CTYPE_W-1:0] ctype;
        logic               cts;
    } hdr_t;

    // Payload length in bits selected by a size code.
    function automatic int payload_bits(input logic [SIZE_W-1:0] code);
        return BASE_BITS << code;
    endfunction

endpackage

// File: rtl/df_sync_hunter.sv
// Sliding-window sync detector.
// Shifts valid bits in MSB-first while enabled and flags a match on the bit that completes it.
// The fill counter makes sure a match uses only bits taken since hunting began.
module df_sync_hunter #(
    parameter int                SYNC_W    = 16,
    parameter logic [SYNC_W-1:0] SYNC_WORD = 16'hF0A5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic bit_in,
    input  logic bit_vld,
    output logic found
);
    localparam int FILL_W = $clog2(SYNC_W + 1);

    logic [SYNC_W-1:0] win_q;
    logic [SYNC_W-1:0] win_next;
    logic [FILL_W-1:0] fill_q;

    assign win_next = {win_q[SYNC_W-2:0], bit_in};
    assign found    = enable && bit_vld &&
                      (fill_q == FILL_W'(SYNC_W - 1)) &&
                      (win_next == SYNC_WORD);

    // Window shift and saturating fill count, restarted whenever hunting is off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q  <= '0;
            fill_q <= '0;
        end else if (!enable) begin
            fill_q <= '0;
        end else if (bit_vld) begin
            win_q <= win_next;
            if (fill_q != FILL_W'(SYNC_W - 1)) begin
                fill_q <= fill_q + FILL_W'(1);
            end
        end
    end

endmodule

// File: rtl/df_frame_ctrl.sv
// Frame sequencer: hunt, header capture and decode, payload bit counting.
// Produces the per-word strobes and tags consumed by the word packer.
// Assumes WORD_W is a power of two between 2 and 8, so every payload is a whole number of words.
module df_frame_ctrl
    import deframer_pkg::*;
#(
    parameter int                 WORD_W   = 8,
    parameter int                 MAX_BITS = 1024,
    parameter logic [CTYPE_W-1:0] IQ_TYPE  = 4'h1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_in,
    input  logic               bit_vld,
    input  logic               sync_found,
    output logic               hunt_en,
    output logic               shift_en,
    output logic               emit,
    output logic               tag_q,
    output logic               tag_sof,
    output logic               tag_eof,
    output logic               frame_done,
    output logic               frame_err,
    output logic               frame_iq,
    output logic [CTYPE_W-1:0] chan_type,
    output logic               cts
);
    localparam int CNT_W = $clog2(LONGEST_BITS);
    localparam int LOGW  = $clog2(WORD_W);

    df_state_t         state_q;
    logic [HDR_W-2:0]  hdr_sr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  len_m1_q;
    hdr_t              hdr_now;
    logic              hdr_fits;
    logic              last_bit;

    assign hdr_now  = hdr_t'({hdr_sr_q, bit_in});
    assign hdr_fits = payload_bits(hdr_now.size) <= MAX_BITS;

    assign hunt_en  = (state_q == ST_HUNT);
    assign shift_en = (state_q == ST_BODY) && bit_vld;
    assign emit     = shift_en && (cnt_q[LOGW-1:0] == '1);
    assign last_bit = shift_en && (cnt_q == len_m1_q);
    assign tag_q    = frame_iq && cnt_q[LOGW];
    assign tag_sof  = !frame_iq && (cnt_q < CNT_W'(WORD_W));
    assign tag_eof  = !frame_iq && (cnt_q == len_m1_q);

    // State sequencing, header decode and per-frame registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_HUNT;
            hdr_sr_q   <= '0;
            cnt_q      <= '0;
            len_m1_q   <= '0;
            frame_done <= 1'b0;
            frame_err  <= 1'b0;
            frame_iq   <= 1'b0;
            chan_type  <= '0;
            cts        <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            frame_err  <= 1'b0;
            case (state_q)
                ST_HUNT: begin
                    if (sync_found) begin
                        state_q <= ST_HDR;
                        cnt_q   <= '0;
                    end
                end
                ST_HDR: begin
                    if (bit_vld) begin
                        hdr_sr_q <= {hdr_sr_q[HDR_W-3:0], bit_in};
                        cnt_q    <= cnt_q + CNT_W'(1);
                        if (cnt_q == CNT_W'(HDR_W - 1)) begin
                            cnt_q <= '0;
                            if (hdr_fits) begin
                                state_q   <= ST_BODY;
                                chan_type <= hdr_now.ctype;
                                cts       <= hdr_now.cts;
                                frame_iq  <= (hdr_now.ctype == IQ_TYPE);
                                len_m1_q  <= CNT_W'(payload_bits(hdr_now.size) - 1);
                            end else begin
                                state_q   <= ST_HUNT;
                                frame_err <= 1'b1;
                            end
                        end
                    end
                end
                ST_BODY: begin
                    if (bit_vld) begin
                        cnt_q <= cnt_q + CNT_W'(1);
                        if (last_bit) begin
                            state_q    <= ST_HUNT;
                            frame_done <= 1'b1;
                        end
                    end
                end
                default: state_q <= ST_HUNT;
            endcase
        end
    end

endmodule

// File: rtl/df_word_packer.sv
// Serial-to-parallel word assembler with registered tags.
// Shifts payload bits MSB-first and, on emit, registers the completed word with its tags for one cycle.
module df_word_packer #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_in,
    input  logic              shift_en,
    input  logic              emit,
    input  logic              tag_q,
    input  logic              tag_sof,
    input  logic              tag_eof,
    output logic [WORD_W-1:0] word_data,
    output logic              word_vld,
    output logic              word_q,
    output logic              word_sof,
    output logic              word_eof
);
    logic [WORD_W-1:0] sh_q;
    logic [WORD_W-1:0] sh_next;

    assign sh_next = {sh_q[WORD_W-2:0], bit_in};

    // Bit shifting and word/tag output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q      <= '0;
            word_data <= '0;
            word_vld  <= 1'b0;
            word_q    <= 1'b0;
            word_sof  <= 1'b0;
            word_eof  <= 1'b0;
        end else begin
            word_vld <= emit;
            word_q   <= emit && tag_q;
            word_sof <= emit && tag_sof;
            word_eof <= emit && tag_eof;
            if (shift_en) begin
                sh_q <= sh_next;
            end
            if (emit) begin
                word_data <= sh_next;
            end
        end
    end

endmodule

// File: rtl/pkt_deframer.sv
// Top level of the serial packet deframer.
// Wires the sync hunter, the frame sequencer and the word packer together.
// Assumes one qualified bit per cycle at most and a synchronous active-low reset.
module pkt_deframer
    import deframer_pkg::*;
#(
    parameter logic [15:0]        SYNC_WORD = 16'hF0A5,
    parameter int                 WORD_W    = 8,
    parameter int                 MAX_BITS  = 1024,
    parameter logic [CTYPE_W-1:0] IQ_TYPE   = 4'h1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_in,
    input  logic               bit_vld,
    output logic [WORD_W-1:0]  word_data,
    output logic               word_vld,
    output logic               word_q,
    output logic               word_sof,
    output logic               word_eof,
    output logic               frame_done,
    output logic               frame_err,
    output logic               frame_iq,
    output logic [CTYPE_W-1:0] chan_type,
    output logic               cts
);
    logic hunt_en;
    logic sync_found;
    logic shift_en;
    logic emit;
    logic tag_q;
    logic tag_sof;
    logic tag_eof;

    df_sync_hunter #(
        .SYNC_W    (16),
        .SYNC_WORD (SYNC_WORD)
    ) u_hunt (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (hunt_en),
        .bit_in  (bit_in),
        .bit_vld (bit_vld),
        .found   (sync_found)
    );

    df_frame_ctrl #(
        .WORD_W   (WORD_W),
        .MAX_BITS (MAX_BITS),
        .IQ_TYPE  (IQ_TYPE)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_in     (bit_in),
        .bit_vld    (bit_vld),
        .sync_found (sync_found),
        .hunt_en    (hunt_en),
        .shift_en   (shift_en),
        .emit       (emit),
        .tag_q      (tag_q),
        .tag_sof    (tag_sof),
        .tag_eof    (tag_eof),
        .frame_done (frame_done),
        .frame_err  (frame_err),
        .frame_iq   (frame_iq),
        .chan_type  (chan_type),
        .cts        (cts)
    );

    df_word_packer #(
        .WORD_W (WORD_W)
    ) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_in    (bit_in),
        .shift_en  (shift_en),
        .emit      (emit),
        .tag_q     (tag_q),
        .tag_sof   (tag_sof),
        .tag_eof   (tag_eof),
        .word_data (word_data),
        .word_vld  (word_vld),
        .word_q    (word_q),
        .word_sof  (word_sof),
        .word_eof  (word_eof)
    );

endmodule

// File: rtl/df_checker.sv
// Temporal checks on the deframer ports, attached to every instance of the top by bind.
module df_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       word_vld,
    input logic       word_q,
    input logic       word_sof,
    input logic       word_eof,
    input logic       frame_done,
    input logic       frame_err,
    input logic       frame_iq,
    input logic [3:0] chan_type,
    input logic       cts
);
    logic seen_q;
    logic last_q;

    // Tracks whether the current frame has produced a word yet, and the tag of that word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            last_q <= 1'b0;
        end else if (word_vld) begin
            seen_q <= !frame_done;
            last_q <= word_q;
        end
    end

    p_hold_type_r4: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |-> ($stable(chan_type) && $stable(cts) && $stable(frame_iq)));

    p_iq_no_marks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld && frame_iq) |-> (!word_sof && !word_eof));

    p_iq_first_i_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld && frame_iq && !seen_q) |-> !word_q);

    p_iq_alternate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld && frame_iq && seen_q) |-> (word_q != last_q));

    p_eof_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        word_eof |-> frame_done);

    p_done_with_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> word_vld);

    p_err_no_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> (!word_vld && !frame_done));

endmodule

bind pkt_deframer df_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_vld   (word_vld),
    .word_q     (word_q),
    .word_sof   (word_sof),
    .word_eof   (word_eof),
    .frame_done (frame_done),
    .frame_err  (frame_err),
    .frame_iq   (frame_iq),
    .chan_type  (chan_type),
    .cts        (cts)
);

// File: tb/sim_pkt_deframer.sv
`timescale 1ns/1ps
// Directed bench: each task drives one scenario and checks its own results.
module sim_pkt_deframer;
    localparam logic [15:0] SYNC = 16'hF0A5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_in = 1'b0;
    logic       bit_vld = 1'b0;
    logic [7:0] word_data;
    logic       word_vld, word_q, word_sof, word_eof;
    logic       frame_done, frame_err, frame_iq, cts;
    logic [3:0] chan_type;

    int n_chk = 0;
    int n_err = 0;
    int n_words, n_done, n_fe;
    logic [7:0] cap_w   [64];
    logic       cap_q   [64];
    logic       cap_sof [64];
    logic       cap_eof [64];
    logic [7:0] tx      [64];
    bit   gap_on = 1'b0;
    int   gap_cnt = 0;

    always #2.5 clk = ~clk;

    pkt_deframer #(.MAX_BITS(256)) u0 (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld),
        .word_data(word_data), .word_vld(word_vld), .word_q(word_q),
        .word_sof(word_sof), .word_eof(word_eof), .frame_done(frame_done),
        .frame_err(frame_err), .frame_iq(frame_iq), .chan_type(chan_type), .cts(cts)
    );

    // Output capture on the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (word_vld && n_words < 64) begin
                cap_w[n_words]   = word_data;
                cap_q[n_words]   = word_q;
                cap_sof[n_words] = word_sof;
                cap_eof[n_words] = word_eof;
                n_words++;
            end
            if (frame_done) n_done++;
            if (frame_err)  n_fe++;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_cap();
        n_words = 0; n_done = 0; n_fe = 0; gap_cnt = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            bit_vld = 1'b0;
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        bit_in  = b;
        bit_vld = 1'b1;
        if (gap_on) begin
            gap_cnt++;
            if (gap_cnt % 3 == 0) begin
                @(negedge clk);
                bit_vld = 1'b0;
                bit_in  = ~b;
            end
        end
    endtask

    task automatic send_frame(input logic [2:0] code, input logic [3:0] ct,
                              input logic c, input int nbytes);
        logic [7:0] hdr;
        hdr = {code, ct, c};
        for (int i = 15; i >= 0; i--) send_bit(SYNC[i]);
        for (int i = 7; i >= 0; i--) send_bit(hdr[i]);
        for (int k = 0; k < nbytes; k++)
            for (int i = 7; i >= 0; i--) send_bit(tx[k][i]);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 word_vld", int'(word_vld), 0);
        check("R1 chan_type", int'(chan_type), 0);
        check("R1 cts", int'(cts), 0);
        check("R1 done/err", int'({frame_done, frame_err}), 0);
        // Reset in the middle of a header, then a clean frame must decode.
        clear_cap();
        for (int i = 15; i >= 0; i--) send_bit(SYNC[i]);
        send_bit(1'b0); send_bit(1'b1);
        @(negedge clk); bit_vld = 1'b0; rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R1 mid-frame reset chan_type", int'(chan_type), 0);
        tx[0] = 8'h3C;
        send_frame(3'd0, 4'h2, 1'b1, 1);
        idle(3);
        check("R1 frame after reset words", n_words, 1);
        check("R1 frame after reset data", int'(cap_w[0]), 'h3C);
    endtask

    task automatic t_iq_frame();
        clear_cap();
        send_bit(1); send_bit(0); send_bit(1); send_bit(1); send_bit(0);
        tx[0] = 8'hC3; tx[1] = 8'h7E;
        send_frame(3'd1, 4'h1, 1'b1, 2);
        idle(3);
        check("R2 R7 word count after offset sync", n_words, 2);
        check("R7 I word data", int'(cap_w[0]), 'hC3);
        check("R7 Q word data", int'(cap_w[1]), 'h7E);
        check("R5 tags I then Q", int'({cap_q[0], cap_q[1]}), 'b01);
        check("R5 no sof/eof", int'({cap_sof[0], cap_eof[1]}), 0);
        check("R7 done count", n_done, 1);
        check("R3 R4 chan_type", int'(chan_type), 1);
        check("R3 R4 cts", int'(cts), 1);
        check("R5 frame_iq", int'(frame_iq), 1);
    endtask

    task automatic t_ctrl_gaps();
        clear_cap();
        gap_on = 1'b1;
        for (int k = 0; k < 4; k++) tx[k] = 8'(8'h11 * (k + 3));
        send_frame(3'd2, 4'h6, 1'b0, 4);
        gap_on = 1'b0;
        idle(3);
        check("R10 R7 word count with gaps", n_words, 4);
        for (int k = 0; k < 4; k++)
            check("R10 word data with gaps", int'(cap_w[k]), int'(8'(8'h11 * (k + 3))));
        check("R6 sof flags", int'({cap_sof[0], cap_sof[1], cap_sof[2], cap_sof[3]}), 'b1000);
        check("R6 eof flags", int'({cap_eof[0], cap_eof[1], cap_eof[2], cap_eof[3]}), 'b0001);
        check("R6 no q tag", int'({cap_q[0], cap_q[1], cap_q[2], cap_q[3]}), 0);
        check("R4 ctrl chan_type", int'(chan_type), 6);
        check("R4 ctrl frame_iq", int'(frame_iq), 0);
    endtask

    task automatic t_err();
        clear_cap();
        send_frame(3'd6, 4'h3, 1'b1, 0);
        idle(2);
        check("R8 err pulse", n_fe, 1);
        check("R8 no words", n_words, 0);
        check("R8 chan_type kept", int'(chan_type), 6);
        check("R8 cts kept", int'(cts), 0);
        tx[0] = 8'h5A;
        send_frame(3'd0, 4'h9, 1'b1, 1);
        idle(3);
        check("R8 frame after error", int'(cap_w[0]), 'h5A);
        check("R8 chan_type after error", int'(chan_type), 9);
    endtask

    task automatic t_back_to_back();
        clear_cap();
        tx[0] = SYNC[15:8]; tx[1] = SYNC[7:0];
        send_frame(3'd1, 4'h2, 1'b1, 2);
        tx[0] = 8'h96;
        send_frame(3'd0, 4'h1, 1'b0, 1);
        idle(3);
        check("R9 total words", n_words, 3);
        check("R9 sync in payload kept as data", int'({cap_w[0], cap_w[1]}), int'(SYNC));
        check("R9 second frame data", int'(cap_w[2]), 'h96);
        check("R9 done count", n_done, 2);
        check("R9 second chan_type", int'(chan_type), 1);
    endtask

    task automatic t_max_iq();
        int bad;
        clear_cap();
        bad = 0;
        for (int k = 0; k < 32; k++) tx[k] = 8'(k * 29 + 7);
        send_frame(3'd5, 4'h1, 1'b0, 32);
        idle(3);
        check("R3 R7 boundary word count", n_words, 32);
        for (int k = 0; k < 32; k++)
            if (cap_w[k] != 8'(k * 29 + 7) || cap_q[k] != k[0]) bad++;
        check("R5 R7 boundary data and tags", bad, 0);
        check("R7 boundary done", n_done, 1);
    endtask

    initial begin
        clear_cap();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_iq_frame();
        t_ctrl_gaps();
        t_err();
        t_back_to_back();
        t_max_iq();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule